// File: doc/BRIEF.md
# Table Lookup Byte Translation Unit

This execution unit carries out a single-byte table translate. When a start pulse arrives with the activating opcode, it takes the accumulator's low byte as an unsigned index and adds it to the base register. The sum is taken in 16 or 32 bits, as the address-size flag selects. The unit then picks a segment and adds that segment's base to form a linear address. It reads one byte over a request/acknowledge memory port and hands the byte back as a write into the accumulator's low byte. No status flag is touched.

Before the read, the unit checks the offset against a limit. In real and virtual-8086 modes the limit is a fixed 64 KiB window. In protected mode it is the selected segment's limit input. A violation ends the operation without any read and reports a fault vector. A page fault reported by the memory port is forwarded with its code, except in real mode where paging is off. Segment bases, segment limits and page-fault status all come from outside the block.

Top module: `tbl_xlate_unit`

## Requirements
- R1: An operation starts only when `start` is high, the unit is idle and `opcode` equals 0xD7. Any other opcode causes no memory request and no `done`.
- R2: With `addr32`=0 the offset is (`base_reg[15:0]` + zero-extended `acc_lo`) mod 2^16. Upper base bits are ignored.
- R3: With `addr32`=1 the offset is (`base_reg` + zero-extended `acc_lo`) mod 2^32.
- R4: Segments are numbered 0..5, and segment 3 (data) is the default. When `seg_ovr_vld`=1 and `seg_ovr_idx`<6, that segment is used instead; indices 6 and 7 fall back to segment 3. The read address is (selected segment base + offset) mod 2^32.
- R5: On success, `done` and `acc_we` pulse together, `acc_wdata` carries the fetched byte and `flt_valid`=0. Count the start cycle as cycle 1. With zero wait states `done` is high in cycle 5, and each wait state adds one cycle.
- R6: `mode` encodes 00 real, 01 protected, 10 virtual-8086 and 11 protected. In real or virtual-8086 mode, an offset above 0xFFFF ends the operation in cycle 4 with `flt_valid`=1, `flt_vec`=13 and `flt_code`=0, and issues no read.
- R7: In protected mode (01 or 11), an offset above the selected segment's limit ends the operation in cycle 4 with no read and `flt_code`=0. The vector is 12 when segment 2 (stack) is selected and 13 otherwise.
- R8: An acknowledge with `mem_pf`=1 in protected or virtual-8086 mode ends the operation with `flt_vec`=14, `flt_code`=`mem_pf_code` and no accumulator write. In real mode `mem_pf` is ignored and the byte is delivered.
- R9: `mem_req` and `mem_addr` stay stable until `mem_ack`. Each operation makes exactly one read, and none when a limit fault occurs.
- R10: `done` lasts one cycle and comes with exactly one of `acc_we` and `flt_valid`. Neither of them is high without `done`, and all are low after reset.
- R11: `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request |
| opcode | input | 8 | Decoded opcode byte |
| addr32 | input | 1 | 1 = 32-bit address size, 0 = 16-bit |
| mode | input | 2 | Operating mode (00 real, 01/11 protected, 10 virtual-8086) |
| seg_ovr_vld | input | 1 | Segment override present |
| seg_ovr_idx | input | SEGW | Override segment number |
| base_reg | input | OW | Table base register |
| acc_lo | input | DW | Accumulator low byte (table index) |
| seg_base_all | input | NSEG*AW | Packed segment bases, segment i at bits i*AW |
| seg_lim_all | input | NSEG*OW | Packed segment limits, segment i at bits i*OW |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Linear byte address |
| mem_ack | input | 1 | Read acknowledge |
| mem_rdata | input | DW | Read data |
| mem_pf | input | 1 | Page fault reported with acknowledge |
| mem_pf_code | input | ECW | Page fault code |
| done | output | 1 | Operation finished (one cycle) |
| acc_we | output | 1 | Accumulator low-byte write enable |
| acc_wdata | output | DW | Byte to write |
| flt_valid | output | 1 | Operation ended in a fault |
| flt_vec | output | 8 | Fault vector |
| flt_code | output | ECW | Fault error code |

## Verification
The assertions watch every cycle for the port protocol. They check that the request and address hold until acknowledge, and that a request rises only three cycles after an accepted 0xD7 start. They also check that `done` carries exactly one of write or fault, that a written byte is the one acknowledged, that a page-fault vector follows a faulting acknowledge, and that limit faults come without a read. Only the bench's sweeps can show the arithmetic. That covers 16-bit wrap against 32-bit sums, segment choice and fallback for out-of-range override numbers, the limit thresholds and the vector choice per mode and segment, exact latency under wait states, and real mode ignoring page faults.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OFS  = 2'd1,
      ST_CHK  = 2'd2,
      ST_MEM  = 2'd3
   } tblx_state_e;

   localparam logic [1:0] MD_REAL  = 2'b00;
   localparam logic [1:0] MD_PROT  = 2'b01;
   localparam logic [1:0] MD_V86   = 2'b10;
   localparam logic [1:0] MD_PROT2 = 2'b11;

   // Real and virtual-8086 modes share the fixed 64 KiB window
   function automatic logic flat_window(input logic [1:0] m);
      return (m == MD_REAL) || (m == MD_V86);
   endfunction

   // Paging faults are only meaningful outside real mode
   function automatic logic paging_live(input logic [1:0] m);
      return m != MD_REAL;
   endfunction

endpackage

// File: rtl/tblx_seg_sel.sv
module tblx_seg_sel #(
   parameter int NSEG     = 6,
   parameter int SEGW     = 3,
   parameter int AW       = 32,
   parameter int OW       = 32,
   parameter int DFLT_SEG = 3
) (
   input  logic                 ovr_vld,
   input  logic [SEGW-1:0]      ovr_idx,
   input  logic [NSEG*AW-1:0]   base_all,
   input  logic [NSEG*OW-1:0]   lim_all,
   output logic [SEGW-1:0]      sel_idx,
   output logic [AW-1:0]        sel_base,
   output logic [OW-1:0]        sel_lim
);

   logic [AW-1:0] base_arr [NSEG];
   logic [OW-1:0] lim_arr  [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_unpack
      assign base_arr[g] = base_all[g*AW +: AW];
      assign lim_arr[g]  = lim_all[g*OW +: OW];
   end

   always_comb begin
      if (ovr_vld && (int'(ovr_idx) < NSEG))
         sel_idx = ovr_idx;
      else
         sel_idx = SEGW'(DFLT_SEG);
   end

   always_comb begin
      sel_base = '0;
      sel_lim  = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (i == int'(sel_idx)) begin
            sel_base = base_arr[i];
            sel_lim  = lim_arr[i];
         end
      end
   end

endmodule

// File: rtl/tblx_offset_gen.sv
module tblx_offset_gen #(
   parameter int OW = 32,
   parameter int DW = 8
) (
   input  logic [OW-1:0] base,
   input  logic [DW-1:0] idx,
   input  logic          wide,
   output logic [OW-1:0] off
);

   logic [15:0]   sum_narrow;
   logic [OW-1:0] sum_wide;

   // index is always zero-extended; narrow sum wraps at 16 bits
   assign sum_narrow = base[15:0] + 16'(idx);
   assign sum_wide   = base + OW'(idx);
   assign off        = wide ? sum_wide : OW'(sum_narrow);

endmodule

// File: rtl/tblx_limit_chk.sv
module tblx_limit_chk
   import tblx_pkg::*;
#(
   parameter int          OW       = 32,
   parameter int          SEGW     = 3,
   parameter int          STK_SEG  = 2,
   parameter int          RM_LIMIT = 'hFFFF,
   parameter logic [7:0]  VEC_RM   = 8'd13,
   parameter logic [7:0]  VEC_GP   = 8'd13,
   parameter logic [7:0]  VEC_SS   = 8'd12
) (
   input  logic [1:0]      mode,
   input  logic [OW-1:0]   off,
   input  logic [OW-1:0]   lim,
   input  logic [SEGW-1:0] sidx,
   output logic            flt,
   output logic [7:0]      vec
);

   localparam logic [OW-1:0] FLAT_LIM = OW'(RM_LIMIT);

   logic flat;
   logic on_stack;

   assign flat     = flat_window(mode);
   assign on_stack = (int'(sidx) == STK_SEG);

   always_comb begin
      if (flat) begin
         flt = off > FLAT_LIM;
         vec = VEC_RM;
      end else begin
         flt = off > lim;
         vec = on_stack ? VEC_SS : VEC_GP;
      end
   end

endmodule

// File: rtl/tbl_xlate_unit.sv
module tbl_xlate_unit
   import tblx_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          AW       = 32,
   parameter int          OW       = 32,
   parameter int          NSEG     = 6,
   parameter int          SEGW     = 3,
   parameter int          ECW      = 32,
   parameter int          DFLT_SEG = 3,
   parameter int          STK_SEG  = 2,
   parameter int          RM_LIMIT = 'hFFFF,
   parameter bit          HAS_A32  = 1'b1,
   parameter logic [7:0]  OPCODE   = 8'hD7,
   parameter logic [7:0]  VEC_RM   = 8'd13,
   parameter logic [7:0]  VEC_GP   = 8'd13,
   parameter logic [7:0]  VEC_SS   = 8'd12,
   parameter logic [7:0]  VEC_PF   = 8'd14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [7:0]          opcode,
   input  logic                addr32,
   input  logic [1:0]          mode,
   input  logic                seg_ovr_vld,
   input  logic [SEGW-1:0]     seg_ovr_idx,
   input  logic [OW-1:0]       base_reg,
   input  logic [DW-1:0]       acc_lo,
   input  logic [NSEG*AW-1:0]  seg_base_all,
   input  logic [NSEG*OW-1:0]  seg_lim_all,
   output logic                mem_req,
   output logic [AW-1:0]       mem_addr,
   input  logic                mem_ack,
   input  logic [DW-1:0]       mem_rdata,
   input  logic                mem_pf,
   input  logic [ECW-1:0]      mem_pf_code,
   output logic                done,
   output logic                acc_we,
   output logic [DW-1:0]       acc_wdata,
   output logic                flt_valid,
   output logic [7:0]          flt_vec,
   output logic [ECW-1:0]      flt_code
);

   // ---------------- elaboration-time parameter checks ----------------
   if (OW < 16) begin : g_bad_ow
      initial $fatal(1, "tbl_xlate_unit: OW must be at least 16");
   end
   if (AW < OW) begin : g_bad_aw
      initial $fatal(1, "tbl_xlate_unit: AW must not be narrower than OW");
   end
   if (DW > 16) begin : g_bad_dw
      initial $fatal(1, "tbl_xlate_unit: DW must fit the narrow offset");
   end
   if ((2 ** SEGW) < NSEG) begin : g_bad_segw
      initial $fatal(1, "tbl_xlate_unit: SEGW too small for NSEG");
   end
   if ((DFLT_SEG >= NSEG) || (STK_SEG >= NSEG)) begin : g_bad_seg
      initial $fatal(1, "tbl_xlate_unit: segment numbers out of range");
   end

   // ---------------- state ----------------
   tblx_state_e     state_q;
   logic [1:0]      mode_q;
   logic            a32_q;
   logic [OW-1:0]   base_q;
   logic [DW-1:0]   acc_q;
   logic [SEGW-1:0] sidx_q;
   logic [AW-1:0]   sbase_q;
   logic [OW-1:0]   slim_q;
   logic [OW-1:0]   off_q;
   logic [AW-1:0]   lin_q;

   logic            done_q;
   logic            we_q;
   logic [DW-1:0]   wdata_q;
   logic            flt_q;
   logic [7:0]      vec_q;
   logic [ECW-1:0]  code_q;

   // ---------------- datapath ----------------
   logic [SEGW-1:0] sel_idx;
   logic [AW-1:0]   sel_base;
   logic [OW-1:0]   sel_lim;
   logic [OW-1:0]   off_nx;
   logic            lim_flt;
   logic [7:0]      lim_vec;
   logic            accept;

   tblx_seg_sel #(
      .NSEG     (NSEG),
      .SEGW     (SEGW),
      .AW       (AW),
      .OW       (OW),
      .DFLT_SEG (DFLT_SEG)
   ) u_seg (
      .ovr_vld  (seg_ovr_vld),
      .ovr_idx  (seg_ovr_idx),
      .base_all (seg_base_all),
      .lim_all  (seg_lim_all),
      .sel_idx  (sel_idx),
      .sel_base (sel_base),
      .sel_lim  (sel_lim)
   );

   tblx_offset_gen #(
      .OW (OW),
      .DW (DW)
   ) u_ofs (
      .base (base_q),
      .idx  (acc_q),
      .wide (a32_q),
      .off  (off_nx)
   );

   tblx_limit_chk #(
      .OW       (OW),
      .SEGW     (SEGW),
      .STK_SEG  (STK_SEG),
      .RM_LIMIT (RM_LIMIT),
      .VEC_RM   (VEC_RM),
      .VEC_GP   (VEC_GP),
      .VEC_SS   (VEC_SS)
   ) u_lim (
      .mode (mode_q),
      .off  (off_q),
      .lim  (slim_q),
      .sidx (sidx_q),
      .flt  (lim_flt),
      .vec  (lim_vec)
   );

   assign accept = (state_q == ST_IDLE) && start && (opcode == OPCODE);

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MD_REAL;
         a32_q   <= 1'b0;
         base_q  <= '0;
         acc_q   <= '0;
         sidx_q  <= '0;
         sbase_q <= '0;
         slim_q  <= '0;
         off_q   <= '0;
         lin_q   <= '0;
         done_q  <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         flt_q   <= 1'b0;
         vec_q   <= '0;
         code_q  <= '0;
      end else begin
         done_q <= 1'b0;
         we_q   <= 1'b0;
         flt_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  mode_q  <= mode;
                  a32_q   <= HAS_A32 & addr32;
                  base_q  <= base_reg;
                  acc_q   <= acc_lo;
                  sidx_q  <= sel_idx;
                  sbase_q <= sel_base;
                  slim_q  <= sel_lim;
                  state_q <= ST_OFS;
               end
            end
            ST_OFS: begin
               off_q   <= off_nx;
               state_q <= ST_CHK;
            end
            ST_CHK: begin
               lin_q <= sbase_q + AW'(off_q);
               if (lim_flt) begin
                  done_q  <= 1'b1;
                  flt_q   <= 1'b1;
                  vec_q   <= lim_vec;
                  code_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_MEM;
               end
            end
            ST_MEM: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
                  if (paging_live(mode_q) && mem_pf) begin
                     flt_q  <= 1'b1;
                     vec_q  <= VEC_PF;
                     code_q <= mem_pf_code;
                  end else begin
                     we_q    <= 1'b1;
                     wdata_q <= mem_rdata;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q == ST_MEM);
   assign mem_addr  = lin_q;
   assign done      = done_q;
   assign acc_we    = we_q;
   assign acc_wdata = wdata_q;
   assign flt_valid = flt_q;
   assign flt_vec   = vec_q;
   assign flt_code  = code_q;

endmodule

// File: rtl/tblx_chk.sv
module tblx_chk #(
   parameter int          DW     = 8,
   parameter int          AW     = 32,
   parameter logic [7:0]  OPCODE = 8'hD7,
   parameter logic [7:0]  VEC_PF = 8'd14
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [7:0]     opcode,
   input logic           mem_req,
   input logic [AW-1:0]  mem_addr,
   input logic           mem_ack,
   input logic [DW-1:0]  mem_rdata,
   input logic           mem_pf,
   input logic           done,
   input logic           acc_we,
   input logic [DW-1:0]  acc_wdata,
   input logic           flt_valid,
   input logic [7:0]     flt_vec
);

   // R9: request and address held until acknowledge
   a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R1: a read starts exactly three edges after an accepted activating start
   a_r1_req_after_op: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(start && (opcode == OPCODE), 3));

   // R10: done carries exactly one outcome
   a_r10_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (acc_we != flt_valid));

   // R10: no outcome without done
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!acc_we && !flt_valid));

   // R5: written byte is the acknowledged byte
   a_r5_data_src: assert property (@(posedge clk) disable iff (!rst_n)
      acc_we |-> ($past(mem_req && mem_ack) && (acc_wdata == $past(mem_rdata))));

   // R8: page-fault vector only after a faulting acknowledge
   a_r8_pf_src: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && (flt_vec == VEC_PF)) |-> $past(mem_req && mem_ack && mem_pf));

   // R6 / R7: limit faults come without a read
   a_r6_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && (flt_vec != VEC_PF)) |-> !$past(mem_req));

endmodule

bind tbl_xlate_unit tblx_chk #(
   .DW     (DW),
   .AW     (AW),
   .OPCODE (OPCODE),
   .VEC_PF (VEC_PF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .opcode    (opcode),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack),
   .mem_rdata (mem_rdata),
   .mem_pf    (mem_pf),
   .done      (done),
   .acc_we    (acc_we),
   .flt_valid (flt_valid),
   .acc_wdata (acc_wdata),
   .flt_vec   (flt_vec)
);

// File: tb/tb_tbl_xlate_unit.sv
`timescale 1ns/1ps
module tb_tbl_xlate_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic        addr32 = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        seg_ovr_vld = 1'b0;
   logic [2:0]  seg_ovr_idx = 3'd0;
   logic [31:0] base_reg = '0;
   logic [7:0]  acc_lo = '0;
   logic [191:0] seg_base_all;
   logic [191:0] seg_lim_all;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack;
   logic [7:0]  mem_rdata;
   logic        mem_pf = 1'b0;
   logic [31:0] mem_pf_code = '0;
   logic        done, acc_we, flt_valid;
   logic [7:0]  acc_wdata, flt_vec;
   logic [31:0] flt_code;

   logic [31:0] sb [6];
   logic [31:0] sl [6];

   int n_vec = 0;
   int n_bad = 0;
   int waits = 0;
   int wcnt = 0;
   int n_reads = 0;
   logic [31:0] last_addr = '0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 6; i++) begin
         seg_base_all[i*32 +: 32] = sb[i];
         seg_lim_all[i*32 +: 32]  = sl[i];
      end
   end

   function automatic logic [7:0] memf(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
   endfunction

   assign mem_ack   = mem_req && (wcnt >= waits);
   assign mem_rdata = memf(mem_addr);

   always @(posedge clk) begin
      if (mem_req && !mem_ack) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_req && mem_ack) begin
         n_reads   <= n_reads + 1;
         last_addr <= mem_addr;
      end
   end

   tbl_xlate_unit dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .opcode       (opcode),
      .addr32       (addr32),
      .mode         (mode),
      .seg_ovr_vld  (seg_ovr_vld),
      .seg_ovr_idx  (seg_ovr_idx),
      .base_reg     (base_reg),
      .acc_lo       (acc_lo),
      .seg_base_all (seg_base_all),
      .seg_lim_all  (seg_lim_all),
      .mem_req      (mem_req),
      .mem_addr     (mem_addr),
      .mem_ack      (mem_ack),
      .mem_rdata    (mem_rdata),
      .mem_pf       (mem_pf),
      .mem_pf_code  (mem_pf_code),
      .done         (done),
      .acc_we       (acc_we),
      .acc_wdata    (acc_wdata),
      .flt_valid    (flt_valid),
      .flt_vec      (flt_vec),
      .flt_code     (flt_code)
   );

   task automatic check(input string rq, input bit ok,
                        input longint unsigned act, input longint unsigned exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] md, input bit a32, input bit ov,
                        input logic [2:0] oi, input logic [31:0] base,
                        input logic [7:0] acc, input int w, input bit pf,
                        input logic [31:0] pfc, input string rq);
      int eff, elat, lat, r0;
      logic [31:0] off, lin;
      bit flat, lf;
      logic [7:0] ev;
      string rqf;
      eff  = (ov && oi < 3'd6) ? int'(oi) : 3;
      off  = a32 ? base + 32'(acc) : 32'(16'(base[15:0] + 16'(acc)));
      flat = (md == 2'b00) || (md == 2'b10);
      if (flat) begin
         lf = off > 32'hFFFF; ev = 8'd13; rqf = "R6";
      end else begin
         lf = off > sl[eff]; ev = (eff == 2) ? 8'd12 : 8'd13; rqf = "R7";
      end
      lin  = sb[eff] + off;
      elat = lf ? 3 : 4 + w;
      waits = w;
      @(negedge clk);
      mem_pf = pf; mem_pf_code = pfc;
      opcode = 8'hD7; mode = md; addr32 = a32; seg_ovr_vld = ov;
      seg_ovr_idx = oi; base_reg = base; acc_lo = acc; start = 1'b1;
      r0 = n_reads;
      lat = 0;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
         start = 1'b0;
      end
      if (lf) begin
         check({rqf, " latency"}, lat == elat, lat, elat);
         check({rqf, " fault"}, done && flt_valid && !acc_we, {done, flt_valid, acc_we}, 3'b110);
         check({rqf, " vector"}, flt_vec == ev, flt_vec, ev);
         check({rqf, " code"}, flt_code == 0, flt_code, 0);
         check("R9 no read on limit fault", n_reads == r0, n_reads - r0, 0);
      end else if (pf && md != 2'b00) begin
         check("R8 latency", lat == elat, lat, elat);
         check("R8 fault", done && flt_valid && !acc_we, {done, flt_valid, acc_we}, 3'b110);
         check("R8 vector", flt_vec == 8'd14, flt_vec, 14);
         check("R8 code", flt_code == pfc, flt_code, pfc);
         check("R9 one read", n_reads == r0 + 1, n_reads - r0, 1);
      end else begin
         check("R5 latency", lat == elat, lat, elat);
         check("R5 write", done && acc_we && !flt_valid, {done, acc_we, flt_valid}, 3'b110);
         check({rq, " data"}, acc_wdata == memf(lin), acc_wdata, memf(lin));
         check({rq, " address"}, last_addr == lin, last_addr, lin);
         check("R9 one read", n_reads == r0 + 1, n_reads - r0, 1);
      end
      @(negedge clk);
      check("R10 done one cycle", !done && !acc_we && !flt_valid, {done, acc_we, flt_valid}, 0);
      mem_pf = 1'b0;
   endtask

   task automatic bad_op(input logic [7:0] op);
      int r0, nd;
      @(negedge clk);
      opcode = op; mode = 2'b00; addr32 = 1'b0; seg_ovr_vld = 1'b0;
      base_reg = 32'h10; acc_lo = 8'h3; start = 1'b1;
      r0 = n_reads; nd = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (done) nd++;
      end
      check("R1 ignored opcode", nd == 0 && n_reads == r0 && !mem_req, {nd, n_reads - r0}, 0);
   endtask

   initial begin
      for (int i = 0; i < 6; i++) begin
         sb[i] = 32'h0001_0000 * (i + 1) + 32'h100 * i;
         sl[i] = 32'h400 + 32'h100 * i;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset state", !done && !acc_we && !flt_valid && !mem_req,
            {done, acc_we, flt_valid, mem_req}, 0);

      // R2: narrow offset wraps, upper base bits ignored
      for (int a = 0; a < 256; a++)
         do_op(2'b00, 1'b0, 1'b0, 3'd0, 32'hABCD_FF80, 8'(a), 0, 1'b0, 0, "R2");
      // R3 + R6: wide offset in real mode crosses the 64 KiB window
      for (int a = 0; a < 256; a++)
         do_op(2'b00, 1'b1, 1'b0, 3'd0, 32'h0000_FF80, 8'(a), 0, 1'b0, 0, "R3");
      // R6: virtual-8086 uses the same window
      for (int a = 0; a < 256; a += 8)
         do_op(2'b10, 1'b1, 1'b0, 3'd0, 32'h0000_FFC0, 8'(a), 0, 1'b0, 0, "R3");
      do_op(2'b00, 1'b1, 1'b0, 3'd0, 32'h0001_0000, 8'h00, 0, 1'b0, 0, "R3");
      // R7: protected limit on data and on stack via override
      for (int a = 0; a < 256; a++)
         do_op(2'b01, 1'b1, 1'b0, 3'd0, sl[3] - 32'h80, 8'(a), 0, 1'b0, 0, "R3");
      for (int a = 0; a < 256; a += 4)
         do_op(2'b11, 1'b1, 1'b1, 3'd2, sl[2] - 32'h80, 8'(a), 0, 1'b0, 0, "R4");
      // R3: 32-bit wrap around zero in protected mode
      sl[5] = 32'hFFFF_FFFF;
      do_op(2'b01, 1'b1, 1'b1, 3'd5, 32'hFFFF_FFF0, 8'h20, 0, 1'b0, 0, "R3");
      // R4: every override number, valid and not, in real and protected mode
      for (int s = 0; s < 8; s++) begin
         do_op(2'b00, 1'b0, 1'b1, 3'(s), 32'h0000_0120, 8'h5C, 0, 1'b0, 0, "R4");
         do_op(2'b01, 1'b0, 1'b1, 3'(s), 32'h0000_0200, 8'h11, 0, 1'b0, 0, "R4");
         do_op(2'b00, 1'b0, 1'b0, 3'(s), 32'h0000_0040, 8'(s), 0, 1'b0, 0, "R4");
      end
      // R8: page fault forwarded in protected / v86, ignored in real mode
      for (int c = 0; c < 8; c++) begin
         do_op(2'b01, 1'b0, 1'b0, 3'd0, 32'h100, 8'(c), c % 3, 1'b1, 32'h10 + 32'(c), "R8");
         do_op(2'b10, 1'b0, 1'b0, 3'd0, 32'h100, 8'(c), 0, 1'b1, 32'hF0 + 32'(c), "R8");
         do_op(2'b00, 1'b0, 1'b0, 3'd0, 32'h100, 8'(c), 1, 1'b1, 32'h77, "R8");
      end
      // R5: wait states extend latency
      for (int w = 0; w < 6; w++)
         do_op(2'b01, 1'b1, 1'b0, 3'd0, 32'h80, 8'(w * 7), w, 1'b0, 0, "R5");
      // R1: every other opcode is ignored
      for (int o = 0; o < 256; o++)
         if (o != 'hD7) bad_op(8'(o));
      // R11: start held during an operation is ignored
      begin
         int r0, nd;
         waits = 0;
         @(negedge clk);
         opcode = 8'hD7; mode = 2'b00; addr32 = 1'b0; seg_ovr_vld = 1'b0;
         base_reg = 32'h300; acc_lo = 8'h9; start = 1'b1;
         r0 = n_reads; nd = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 2) start = 1'b0;
            if (done) nd++;
         end
         check("R11 busy start ignored", nd == 1 && n_reads == r0 + 1, {nd, n_reads - r0}, 2'b11);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule